// File: doc/BRIEF.md
# Programming Command Scan Register

A 15-bit serial scan register that sits behind a test access port and carries memory-programming commands. While the instruction register holds the programming-command code, the external TAP controller's state strobes drive it. On Capture-DR it loads the result the flash interface returned for the last executed command. On Shift-DR it moves that result out on TDO while a new command word moves in from TDI. On Update-DR it applies the new word to a parallel command bus. Each TCK cycle spent in Run-Test/Idle issues one execute strobe for the applied command.

The low eight bits of the chain also serve as the flash data byte register. When one of the two byte-transfer instruction codes is active, only those eight bits form the scan path. Capture then loads a byte read from the flash. The upper seven bits, the command bus and the execute strobe are left alone in byte mode. The TAP state machine, the instruction register and the flash array are outside this block and appear only as ports.

Top module: `jtag_pcmd_dr`

## Requirements
- R1: With an instruction code other than 0x5, 0x6 or 0x7 on `ir_i`, the capture, shift, update and idle strobes change none of `dbyte_o`, `cmd_o` or `exec_o`.
- R2: With code 0x5 active, a rising TCK edge with `capture_i` high loads all 15 bits of `result_i` into the chain.
- R3: With code 0x5 active, a rising TCK edge with `shift_i` high moves the chain one place toward bit 0 and enters `tdi_i` at bit 14. `tdo_o` takes bit 0 on each falling TCK edge, so the first bit out is bit 0 (LSB first).
- R4: With code 0x5 active, a rising TCK edge with `update_i` high copies the chain to `cmd_o`. At every other edge `cmd_o` keeps its value, including all the time shifting is under way.
- R5: Every rising TCK edge with `idle_i` high and code 0x5 active makes `exec_o` high for the next TCK cycle. Otherwise `exec_o` is low for that cycle, so N idle cycles give exactly N execute cycles.
- R6: A rising edge with `tap_reset_i` high clears `cmd_o` to zero and forces `exec_o` low, even if `idle_i` is also high.
- R7: With code 0x6 or 0x7 active, capture loads `rd_byte_i` into bits 7:0. Shift moves bits 7:0 toward bit 0 and enters `tdi_i` at bit 7. Bits 14:8 are unchanged.
- R8: With code 0x6 or 0x7 active, the update and idle strobes leave `cmd_o` unchanged and `exec_o` low.
- R9: `dbyte_o` always presents chain bits 7:0.
- R10: While `rst_ni` is low, the chain, `cmd_o`, `exec_o`, `tdo_o` and `dbyte_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_i | input | 4 | Current instruction code |
| capture_i | input | 1 | TAP in Capture-DR |
| shift_i | input | 1 | TAP in Shift-DR |
| update_i | input | 1 | TAP in Update-DR |
| idle_i | input | 1 | TAP in Run-Test/Idle |
| tap_reset_i | input | 1 | TAP in Test-Logic-Reset |
| tdi_i | input | 1 | Serial data in |
| result_i | input | 15 | Result of the previously executed command |
| rd_byte_i | input | 8 | Flash byte for byte-mode capture |
| tdo_o | output | 1 | Serial data out, falling-edge timed |
| cmd_o | output | 15 | Applied command word |
| exec_o | output | 1 | Execute strobe, one TCK cycle per idle cycle |
| dbyte_o | output | 8 | Low byte of the chain |

## Verification
The bench builds the block with its default parameters: a 15-bit command chain, an 8-bit shared byte and a 4-bit instruction code. At these widths a full command can be shifted in a few cycles, and the byte path overlaps exactly the low bits of that chain. Byte-mode shifts can therefore be seen later in the upper bits of an applied command. Random mixes of the three decoded codes and an unrelated code reach orderings such as shifting during a pending command, updates after partial shifts, and idle runs interleaved with TAP resets.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_CMD  = 2'd1,
    MODE_BYTE = 2'd2
  } pcmd_mode_e;
endpackage

// File: rtl/pcmd_chain.sv
module pcmd_chain
  import pcmd_pkg::*;
#(
  parameter int CMD_W  = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pcmd_mode_e        mode_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              tap_reset_i,
  input  logic              tdi_i,
  input  logic [CMD_W-1:0]  result_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic [CMD_W-1:0]  sr_o
);
  localparam int HI_W = CMD_W - BYTE_W;

  logic [CMD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (!tap_reset_i) begin
      unique case (mode_i)
        MODE_CMD: begin
          if (capture_i)    sr_q <= result_i;
          else if (shift_i) sr_q <= {tdi_i, sr_q[CMD_W-1:1]};
        end
        MODE_BYTE: begin
          if (capture_i)    sr_q[BYTE_W-1:0] <= rd_byte_i;
          else if (shift_i) sr_q[BYTE_W-1:0] <= {tdi_i, sr_q[BYTE_W-1:1]};
        end
        default: ;
      endcase
    end
  end

  assign sr_o = sr_q;

  // R2
  a_r2_capture_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CMD && capture_i && !tap_reset_i) |=> sr_q == $past(result_i));

  // R3
  a_r3_shift_lsb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CMD && shift_i && !capture_i && !tap_reset_i) |=>
      (sr_q[CMD_W-2:0] == $past(sr_q[CMD_W-1:1])) && (sr_q[CMD_W-1] == $past(tdi_i)));

  // R7
  a_r7_byte_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BYTE) |=> $stable(sr_q[CMD_W-1:CMD_W-HI_W]));

  // R1
  a_r1_idle_code_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NONE) |=> $stable(sr_q));
endmodule

// File: rtl/pcmd_update.sv
module pcmd_update #(
  parameter int CMD_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic             tap_reset_i,
  input  logic [CMD_W-1:0] d_i,
  output logic [CMD_W-1:0] q_o
);
  logic [CMD_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_q <= '0;
    else if (tap_reset_i) q_q <= '0;
    else if (upd_en_i)    q_q <= d_i;
  end

  assign q_o = q_q;

  // R4
  a_r4_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_en_i && !tap_reset_i) |=> $stable(q_q));

  // R6
  a_r6_cmd_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_reset_i |=> (q_q == '0));
endmodule

// File: rtl/pcmd_exec.sv
module pcmd_exec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_en_i,
  input  logic tap_reset_i,
  output logic exec_o
);
  logic exec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exec_q <= 1'b0;
    else         exec_q <= idle_en_i && !tap_reset_i;
  end

  assign exec_o = exec_q;

  // R5
  a_r5_exec_per_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_en_i && !tap_reset_i) |=> exec_q);

  // R5
  a_r5_no_exec_outside_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_en_i |=> !exec_q);

  // R6
  a_r6_exec_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_reset_i |=> !exec_q);
endmodule

// File: rtl/pcmd_tdo.sv
module pcmd_tdo (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit0_i,
  output logic tdo_o
);
  logic tdo_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tdo_q <= 1'b0;
    else         tdo_q <= bit0_i;
  end

  assign tdo_o = tdo_q;

  // R3: bit 0 only moves on rising edges, so at each rising edge tdo matches it
  a_r3_tdo_tracks_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdo_q == bit0_i);
endmodule

// File: rtl/jtag_pcmd_dr.sv
module jtag_pcmd_dr
  import pcmd_pkg::*;
#(
  parameter int              CMD_W     = 15,
  parameter int              BYTE_W    = 8,
  parameter int              IR_W      = 4,
  parameter logic [IR_W-1:0] CODE_CMD  = 4'h5,
  parameter logic [IR_W-1:0] CODE_LOAD = 4'h6,
  parameter logic [IR_W-1:0] CODE_READ = 4'h7
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              idle_i,
  input  logic              tap_reset_i,
  input  logic              tdi_i,
  input  logic [CMD_W-1:0]  result_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              tdo_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              exec_o,
  output logic [BYTE_W-1:0] dbyte_o
);
  pcmd_mode_e       mode;
  logic [CMD_W-1:0] sr;
  logic             upd_en;
  logic             idle_en;

  always_comb begin
    if (ir_i == CODE_CMD)                            mode = MODE_CMD;
    else if (ir_i == CODE_LOAD || ir_i == CODE_READ) mode = MODE_BYTE;
    else                                             mode = MODE_NONE;
  end

  assign upd_en  = update_i && (mode == MODE_CMD);
  assign idle_en = idle_i && (mode == MODE_CMD);

  pcmd_chain #(.CMD_W(CMD_W), .BYTE_W(BYTE_W)) u_chain (
    .clk_i       (tck_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .capture_i   (capture_i),
    .shift_i     (shift_i),
    .tap_reset_i (tap_reset_i),
    .tdi_i       (tdi_i),
    .result_i    (result_i),
    .rd_byte_i   (rd_byte_i),
    .sr_o        (sr)
  );

  pcmd_update #(.CMD_W(CMD_W)) u_update (
    .clk_i       (tck_i),
    .rst_ni      (rst_ni),
    .upd_en_i    (upd_en),
    .tap_reset_i (tap_reset_i),
    .d_i         (sr),
    .q_o         (cmd_o)
  );

  pcmd_exec u_exec (
    .clk_i       (tck_i),
    .rst_ni      (rst_ni),
    .idle_en_i   (idle_en),
    .tap_reset_i (tap_reset_i),
    .exec_o      (exec_o)
  );

  pcmd_tdo u_tdo (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .bit0_i (sr[0]),
    .tdo_o  (tdo_o)
  );

  assign dbyte_o = sr[BYTE_W-1:0];

  // R8
  a_r8_byte_mode_no_cmd_change: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (mode == MODE_BYTE && !tap_reset_i) |=> ($stable(cmd_o) && !exec_o));
endmodule

// File: tb/sim_jtag_pcmd_dr.sv
`timescale 1ns/1ps
module sim_jtag_pcmd_dr;
  logic        tck = 1'b0;
  logic        rst_n;
  logic [3:0]  ir;
  logic        cap, sh, upd, idle, trst, tdi;
  logic [14:0] result;
  logic [7:0]  rd_byte;
  logic        tdo, exec_s;
  logic [14:0] cmd;
  logic [7:0]  dbyte;

  always #2.5 tck = ~tck;

  jtag_pcmd_dr u0 (
    .tck_i(tck), .rst_ni(rst_n), .ir_i(ir), .capture_i(cap), .shift_i(sh),
    .update_i(upd), .idle_i(idle), .tap_reset_i(trst), .tdi_i(tdi),
    .result_i(result), .rd_byte_i(rd_byte), .tdo_o(tdo), .cmd_o(cmd),
    .exec_o(exec_s), .dbyte_o(dbyte)
  );

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  logic [14:0] m_sr, m_cmd;
  logic        m_exec;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic int mode_of(input logic [3:0] code);
    if (code == 4'h5) return 2;
    if (code == 4'h6 || code == 4'h7) return 1;
    return 0;
  endfunction

  task automatic strobe(input int k);
    cap = 0; sh = 0; upd = 0; idle = 0; trst = 0;
    case (k)
      1: cap = 1;
      2: sh = 1;
      3: upd = 1;
      4: idle = 1;
      5: trst = 1;
      default: ;
    endcase
  endtask

  // one rising edge, then past the falling edge; model follows the requirements
  task automatic tick();
    int md;
    @(posedge tck);
    #3;
    md = mode_of(ir);
    if (trst) begin
      m_cmd = '0; m_exec = 1'b0;                 // R6
    end else begin
      m_exec = (md == 2) && idle;                // R5
      if (md == 2) begin
        if (cap)      m_sr = result;             // R2
        else if (sh)  m_sr = {tdi, m_sr[14:1]};  // R3
        else if (upd) m_cmd = m_sr;              // R4
      end else if (md == 1) begin                // R7
        if (cap)      m_sr[7:0] = rd_byte;
        else if (sh)  m_sr[7:0] = {tdi, m_sr[7:1]};
      end
    end
    chk("R4 cmd_o", 32'(cmd), 32'(m_cmd));
    chk("R5 exec_o", 32'(exec_s), 32'(m_exec));
    chk("R3 tdo_o", 32'(tdo), 32'(m_sr[0]));
    chk("R9 dbyte_o", 32'(dbyte), 32'(m_sr[7:0]));
  endtask

  initial begin
    #(200000.0 * 5.0);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic [14:0] got;
    logic [6:0]  upper;
    int          n_exec;
    void'($urandom(32'd1234));
    rst_n = 0; ir = 4'h5; tdi = 0; result = '0; rd_byte = '0;
    strobe(0);
    m_sr = '0; m_cmd = '0; m_exec = 0;
    #6;
    chk("R10 reset cmd_o", 32'(cmd), 0);
    chk("R10 reset exec_o", 32'(exec_s), 0);
    chk("R10 reset tdo_o", 32'(tdo), 0);
    chk("R10 reset dbyte_o", 32'(dbyte), 0);
    #4 rst_n = 1;

    // R2 / R3: capture result and shift it out LSB first while loading a command
    ir = 4'h5; result = 15'h2A5C; strobe(1);
    tick();
    chk("R2 capture bit0 on tdo", 32'(tdo), 32'(result[0]));
    strobe(2);
    for (int k = 0; k < 15; k++) begin
      got[k] = tdo;
      tdi = 1'((15'h1234 >> k) & 1);
      tick();
      chk("R4 cmd held during shift", 32'(cmd), 0);
    end
    chk("R3 shifted-out result", 32'(got), 32'(15'h2A5C));
    strobe(3);
    tick();
    chk("R4 update applies command", 32'(cmd), 32'(15'h1234));

    // R5: three idle cycles give three execute cycles
    strobe(4);
    n_exec = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      if (exec_s) n_exec++;
    end
    chk("R5 execute count", 32'(n_exec), 3);
    strobe(0);
    tick();
    chk("R5 exec low after idle", 32'(exec_s), 0);

    // R7 / R8: byte mode touches only the low byte
    upper = m_sr[14:8];
    ir = 4'h7; rd_byte = 8'hC3; strobe(1);
    tick();
    chk("R7 byte capture", 32'(dbyte), 32'h0C3);
    ir = 4'h6; strobe(2);
    for (int k = 0; k < 8; k++) begin
      tdi = 1'((8'h5A >> k) & 1);
      tick();
    end
    chk("R7 byte shift", 32'(dbyte), 32'h05A);
    strobe(3);
    tick();
    chk("R8 byte update keeps cmd", 32'(cmd), 32'(15'h1234));
    strobe(4);
    tick();
    chk("R8 byte idle no exec", 32'(exec_s), 0);
    ir = 4'h5; strobe(3);
    tick();
    chk("R7 upper bits kept", 32'(cmd[14:8]), 32'(upper));
    chk("R7 low byte in command", 32'(cmd[7:0]), 32'h05A);

    // R1: unrelated code ignores strobes
    ir = 4'h3; result = 15'h7FFF; rd_byte = 8'hFF; tdi = 1;
    for (int k = 1; k <= 4; k++) begin
      strobe(k);
      tick();
      chk("R1 dbyte unchanged", 32'(dbyte), 32'h05A);
      chk("R1 cmd unchanged", 32'(cmd), 32'(m_cmd));
      chk("R1 no exec", 32'(exec_s), 0);
    end

    // R6: TAP reset clears command and blocks execute even with idle high
    ir = 4'h5; strobe(4);
    tick();
    strobe(5); idle = 1;
    tick();
    chk("R6 cmd cleared", 32'(cmd), 0);
    chk("R6 exec suppressed", 32'(exec_s), 0);

    // random mix
    strobe(0);
    for (int it = 0; it < 4000; it++) begin
      int r;
      r = int'($urandom % 5);
      ir = (r < 2) ? 4'h5 : (r == 2) ? 4'h6 : (r == 3) ? 4'h7 : 4'h3;
      r = int'($urandom % 40);
      strobe(r == 0 ? 5 : r % 5);
      tdi = 1'($urandom);
      result = 15'($urandom);
      rd_byte = 8'($urandom);
      tick();
    end
    report();
  end
endmodule